// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Pipeline

This block is a single-port synchronous static memory whose shared data bus never needs an idle cycle between a read and a write. Address and control are registered on the rising clock edge. Write data follows its command by the same number of cycles that read data does. Because the bus slot of every command lands at a fixed distance from the command, a host can interleave reads and writes on every clock.

A mode input chooses between two latencies. In the pipelined latency, read data passes through an output register, and a write's data is taken two edges after its command. In the flow-through latency, both pipelines are one cycle shorter. Writes carry one active-low enable per 9-bit byte. Captured writes wait in two pending stages before they reach the array. Any read whose address matches a pending write gets the merged pending bytes, with the newest bytes winning. Three chip selects, a clock enable that freezes the whole pipeline, and an asynchronous output enable complete the interface.

Top module: `lsram_top`

## Requirements
- R1: With `flowN` high, a read command registered at edge n drives its word on `dq` from just after edge n+1 until edge n+2.
- R2: With `flowN` high, the data of a write command registered at edge n is sampled from `dq` at edge n+2.
- R3: With `flowN` low, a read registered at edge n drives `dq` between edge n and edge n+1, and write data is sampled at edge n+1.
- R4: `flowN` low selects the flow-through latency and `flowN` high selects the pipelined latency. The mode is changed only while no command is in flight.
- R5: A command is accepted only when `selAN` is low, `selB` is high and `selCN` is low. Otherwise the edge starts no operation: nothing is driven in its slot and no word changes.
- R6: `byteEnN[i]` is active low and guards `dq[9*i+8:9*i]`. Any combination is legal. A write with every bit of `byteEnN` high is a no-op and leaves the memory unchanged.
- R7: While `clkEnN` is high, edges are ignored and all state holds. A read in its bus slot keeps driving, and a write slot stays undriven until the stall ends.
- R8: `dq` is driven only in the bus slot of a read. `outEnN` high releases it at once, asynchronously. `dqDrive` reports when the block drives `dq`.
- R9: A read returns the newest data for each byte, even when the write that produced it has not yet reached the array. This includes a write whose data is sampled at the same edge the read data is formed.
- R10: Reads and writes may alternate on consecutive clocks with no idle cycle, and each returns or stores the correct word.
- R11: During and after reset `dq` is undriven and no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkEnN | input | 1 | Clock enable, active low; high freezes the block |
| selAN | input | 1 | Chip select, active low |
| selB | input | 1 | Chip select, active high |
| selCN | input | 1 | Chip select, active low |
| writeN | input | 1 | Low for write, high for read |
| byteEnN | input | NBYTES | Per-byte write enables, active low |
| addr | input | ADDR_W | Word address |
| flowN | input | 1 | Low selects flow-through, high selects pipelined latency |
| outEnN | input | 1 | Asynchronous output enable, active low |
| dq | inout | NBYTES*BYTE_W | Shared bidirectional data bus |
| dqDrive | output | 1 | High while the block drives `dq` |

## Verification
A wrong slot position shows on the bus at once. `dqDrive` rises a cycle early or late, or the host's write word is sampled in the wrong cycle, and the next read of that address returns a stale word. Broken forwarding or a bad pending-stage order is invisible until a read hits a still-pending address; the bench therefore reads immediately after writes, one and two cycles apart, and with overlapping byte masks. Broken stall handling shows as a read slot that stops driving, or as a write that is captured one cycle late.

// File: rtl/lsram_pkg.sv
package lsram_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } cmdKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic advance;    // edge is not frozen
    logic capWrite;   // bus word is taken at this edge
    logic fwdBus;     // bus word may feed a read formed at this edge
    logic flowMode;   // flow-through latency selected
  } strobe_t;

endpackage

// File: rtl/lsram_ctrl.sv
module lsram_ctrl
  import lsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic              selAN,
  input  logic              selB,
  input  logic              selCN,
  input  logic              writeN,
  input  logic [NBYTES-1:0] byteEnN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              flowN,
  output strobe_t           stb,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] capAddr,
  output logic [NBYTES-1:0] capMask,
  output logic              outDrive
);

  logic              selected;
  cmdKind_t          newKind;
  cmdKind_t          s1Kind, s2Kind, slotKind;
  logic [ADDR_W-1:0] s1Addr, s2Addr;
  logic [NBYTES-1:0] s1Mask, s2Mask;
  logic              qValid;
  logic              flowMode;

  always_comb begin
    selected = !selAN && selB && !selCN;
    newKind  = CMD_IDLE;
    if (selected) begin
      if (writeN)            newKind = CMD_READ;
      else if (!(&byteEnN))  newKind = CMD_WRITE;
    end
  end

  // two command stages; the output-valid flag follows stage one
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Kind <= CMD_IDLE;
      s2Kind <= CMD_IDLE;
      s1Addr <= '0;
      s2Addr <= '0;
      s1Mask <= '0;
      s2Mask <= '0;
      qValid <= 1'b0;
    end else if (!clkEnN) begin
      s1Kind <= newKind;
      s1Addr <= addr;
      s1Mask <= ~byteEnN;
      s2Kind <= s1Kind;
      s2Addr <= s1Addr;
      s2Mask <= s1Mask;
      qValid <= (s1Kind == CMD_READ);
    end
  end

  always_comb begin
    flowMode     = !flowN;
    slotKind     = flowMode ? s1Kind : s2Kind;
    capAddr      = flowMode ? s1Addr : s2Addr;
    capMask      = flowMode ? s1Mask : s2Mask;
    rdAddr       = s1Addr;
    stb.advance  = !clkEnN;
    stb.capWrite = !clkEnN && (slotKind == CMD_WRITE);
    stb.fwdBus   = !flowMode && (s2Kind == CMD_WRITE);
    stb.flowMode = flowMode;
    outDrive     = flowMode ? (s1Kind == CMD_READ) : qValid;
  end

  AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && (selAN || !selB || selCN)) |=> (s1Kind == CMD_IDLE)); // R5

  AST_NOOP_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && !writeN && (&byteEnN)) |=> (s1Kind == CMD_IDLE)); // R6

  AST_FROZEN_STAGES: assert property (@(posedge clk) disable iff (!rstN)
    clkEnN |=> ($stable(s1Kind) && $stable(s1Addr) && $stable(qValid))); // R7

  AST_PIPE_OUT_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && s1Kind == CMD_READ) |=> qValid); // R1

  AST_SLOT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(outDrive && stb.capWrite)); // R10

endmodule

// File: rtl/lsram_dp.sv
module lsram_dp
  import lsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 9
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  stb,
  input  logic [ADDR_W-1:0]        rdAddr,
  input  logic [ADDR_W-1:0]        capAddr,
  input  logic [NBYTES-1:0]        capMask,
  input  logic [NBYTES*BYTE_W-1:0] busIn,
  output logic [NBYTES*BYTE_W-1:0] rdData
);

  localparam int DATA_W = NBYTES * BYTE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // newest (A) and older (B) pending writes
  logic              pendAV, pendBV;
  logic [ADDR_W-1:0] pendAAddr, pendBAddr;
  logic [NBYTES-1:0] pendAMask, pendBMask;
  logic [DATA_W-1:0] pendAData, pendBData;
  logic [DATA_W-1:0] merged, qReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendAV    <= 1'b0;
      pendBV    <= 1'b0;
      pendAAddr <= '0;
      pendBAddr <= '0;
      pendAMask <= '0;
      pendBMask <= '0;
      pendAData <= '0;
      pendBData <= '0;
    end else if (stb.capWrite) begin
      pendBV    <= pendAV;
      pendBAddr <= pendAAddr;
      pendBMask <= pendAMask;
      pendBData <= pendAData;
      pendAV    <= 1'b1;
      pendAAddr <= capAddr;
      pendAMask <= capMask;
      pendAData <= busIn;
    end
  end

  // oldest pending write retires into the array when a new one arrives
  always_ff @(posedge clk) begin
    if (stb.capWrite && pendBV) begin
      for (int i = 0; i < NBYTES; i++) begin
        if (pendBMask[i]) mem[pendBAddr][i*BYTE_W +: BYTE_W] <= pendBData[i*BYTE_W +: BYTE_W];
      end
    end
  end

  // array word, overlaid by older, newer, then in-flight bytes
  always_comb begin
    merged = mem[rdAddr];
    for (int i = 0; i < NBYTES; i++) begin
      if (pendBV && pendBAddr == rdAddr && pendBMask[i])
        merged[i*BYTE_W +: BYTE_W] = pendBData[i*BYTE_W +: BYTE_W];
      if (pendAV && pendAAddr == rdAddr && pendAMask[i])
        merged[i*BYTE_W +: BYTE_W] = pendAData[i*BYTE_W +: BYTE_W];
      if (stb.fwdBus && capAddr == rdAddr && capMask[i])
        merged[i*BYTE_W +: BYTE_W] = busIn[i*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            qReg <= '0;
    else if (stb.advance) qReg <= merged;
  end

  assign rdData = stb.flowMode ? merged : qReg;

  AST_PEND_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capWrite && pendAV) |=> pendBV); // R9

  AST_OUTREG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.advance |=> $stable(qReg)); // R7

  AST_PEND_NEWEST: assert property (@(posedge clk) disable iff (!rstN)
    stb.capWrite |=> (pendAV && pendAAddr == $past(capAddr))); // R2

endmodule

// File: rtl/lsram_top.sv
module lsram_top
  import lsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 9
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     clkEnN,
  input  logic                     selAN,
  input  logic                     selB,
  input  logic                     selCN,
  input  logic                     writeN,
  input  logic [NBYTES-1:0]        byteEnN,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     flowN,
  input  logic                     outEnN,
  inout  wire  [NBYTES*BYTE_W-1:0] dq,
  output logic                     dqDrive
);

  localparam int DATA_W = NBYTES * BYTE_W;

  strobe_t           stb;
  logic [ADDR_W-1:0] rdAddr, capAddr;
  logic [NBYTES-1:0] capMask;
  logic              outDrive;
  logic [DATA_W-1:0] rdData;

  lsram_ctrl #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) ctrl_i (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .selAN(selAN), .selB(selB),
    .selCN(selCN), .writeN(writeN), .byteEnN(byteEnN), .addr(addr),
    .flowN(flowN), .stb(stb), .rdAddr(rdAddr), .capAddr(capAddr),
    .capMask(capMask), .outDrive(outDrive)
  );

  lsram_dp #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .rdAddr(rdAddr), .capAddr(capAddr),
    .capMask(capMask), .busIn(dq), .rdData(rdData)
  );

  assign dqDrive = outDrive && !outEnN;
  assign dq      = dqDrive ? rdData : 'z;

  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> !dqDrive); // R8

endmodule

// File: tb/lsram_top_tb_top.sv
`timescale 1ns/1ps
module lsram_top_tb_top;

  localparam int AW = 6;
  localparam int NB = 4;
  localparam int BW = 9;
  localparam int DW = NB * BW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rstN, clkEnN, selAN, selB, selCN, writeN, flowN, outEnN;
  logic [NB-1:0] byteEnN;
  logic [AW-1:0] addr;
  logic          tbDrv;
  logic [DW-1:0] tbData;
  wire  [DW-1:0] dqBus;
  wire           dqDrive;

  assign dqBus = tbDrv ? tbData : 'z;

  lsram_top #(.ADDR_W(AW), .NBYTES(NB), .BYTE_W(BW)) dut_i (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .selAN(selAN), .selB(selB),
    .selCN(selCN), .writeN(writeN), .byteEnN(byteEnN), .addr(addr),
    .flowN(flowN), .outEnN(outEnN), .dq(dqBus), .dqDrive(dqDrive)
  );

  typedef struct {
    int            due;
    bit            isWr;
    logic [DW-1:0] data;
    bit            oeOff;
    string         req;
  } item_t;

  item_t         q[$];
  logic [DW-1:0] model [1<<AW];
  int            cyc = 0;
  int            checks = 0;
  int            errors = 0;
  bit            monOn = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int k);
    return {4'(k), 8'(a), 24'(a * 7919 + k * 104729 + 1)};
  endfunction

  function automatic int lat();
    return flowN ? 2 : 1;
  endfunction

  // driver: one command per cycle, expected slot items pushed in order
  task automatic issue(input int kind, input int a, input logic [NB-1:0] beN,
                       input logic [DW-1:0] d, input int selMiss, input bit oe,
                       input string req);
    item_t it;
    @(negedge clk);
    clkEnN  = 1'b0;
    selAN   = (kind == 0) || (selMiss == 1);
    selB    = (selMiss != 2);
    selCN   = (selMiss == 3);
    writeN  = (kind != 2);
    byteEnN = (kind == 2) ? beN : '1;
    addr    = AW'(a);
    if (selMiss == 0 && kind == 1) begin
      it = '{due: cyc + lat(), isWr: 1'b0, data: model[a], oeOff: oe, req: req};
      q.push_back(it);
    end
    if (selMiss == 0 && kind == 2 && beN != '1) begin
      for (int i = 0; i < NB; i++)
        if (!beN[i]) model[a][i*BW +: BW] = d[i*BW +: BW];
      it = '{due: cyc + lat(), isWr: 1'b1, data: d, oeOff: 1'b0, req: req};
      q.push_back(it);
    end
  endtask

  task automatic stall();
    item_t it;
    int    n;
    @(negedge clk);
    clkEnN = 1'b1;
    n = q.size();
    for (int i = 0; i < n; i++) begin
      if (q[i].due > cyc) q[i].due++;
      else if (q[i].due == cyc) begin
        it = q[i];
        it.due = cyc + 1;
        it.req = "R7";
        q.push_back(it);
      end
    end
  endtask

  // host bus release shortly after each edge
  initial begin
    tbDrv  = 1'b0;
    tbData = '0;
    forever begin
      @(posedge clk);
      #0.1;
      tbDrv = 1'b0;
    end
  end

  // monitor: services the bus slot of the current cycle
  initial begin
    outEnN = 1'b0;
    forever begin
      @(negedge clk);
      if (monOn) begin
        int idx;
        #0.2;
        idx = -1;
        for (int i = 0; i < q.size(); i++)
          if (idx < 0 && q[i].due == cyc) idx = i;
        if (idx < 0) begin
          check(!dqDrive, "R8", "bus driven in empty slot", DW'(dqDrive), '0);
        end else if (q[idx].isWr) begin
          check(!dqDrive, "R8", "bus driven in write slot", DW'(dqDrive), '0);
          tbData = q[idx].data;
          tbDrv  = 1'b1;
        end else begin
          check(dqDrive && dqBus === q[idx].data, q[idx].req, "read word",
                dqBus, q[idx].data);
          if (q[idx].oeOff) begin
            outEnN = 1'b1;
            #0.2;
            check(!dqDrive, "R8", "output enable release", DW'(dqDrive), '0);
            outEnN = 1'b0;
            #0.2;
            check(dqDrive, "R8", "output enable restore", DW'(dqDrive), DW'(1));
          end
        end
        for (int i = q.size() - 1; i >= 0; i--)
          if (q[i].due <= cyc) q.delete(i);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung actual=%0d expected=%0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; clkEnN = 1'b0; selAN = 1'b1; selB = 1'b0; selCN = 1'b1;
    writeN = 1'b1; byteEnN = '1; addr = '0; flowN = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(!dqDrive, "R11", "drive during reset", DW'(dqDrive), '0);
    end
    @(negedge clk);
    rstN = 1'b1;
    monOn = 1'b1;

    // pipelined latency (R1, R2)
    for (int a = 0; a < 64; a++) issue(2, a, '0, pat(a, 0), 0, 0, "R2");
    for (int a = 0; a < 8; a++) issue(1, a, '1, '0, 0, 0, "R1");
    for (int i = 0; i < 8; i++) begin
      issue(2, 8 + i, '0, pat(8 + i, 1), 0, 0, "R10");
      issue(1, 20 + i, '1, '0, 0, 0, "R10");
    end
    for (int i = 0; i < 4; i++) issue(1, 8 + i, '1, '0, 0, 0, "R10");
    // read right behind a write: forwarding from the bus and pending stages
    issue(2, 5, '0, pat(5, 2), 0, 0, "R9");
    issue(1, 5, '1, '0, 0, 0, "R9");
    issue(1, 5, '1, '0, 0, 0, "R9");
    issue(2, 6, 4'b1110, pat(6, 3), 0, 0, "R6");
    issue(2, 6, 4'b0101, pat(6, 4), 0, 0, "R9");
    issue(1, 6, '1, '0, 0, 0, "R6");
    issue(0, 0, '1, '0, 0, 0, "R6");
    issue(1, 6, '1, '0, 0, 0, "R9");
    // write with no byte enabled
    issue(2, 7, 4'b1111, pat(7, 9), 0, 0, "R6");
    issue(0, 0, '1, '0, 0, 0, "R6");
    issue(1, 7, '1, '0, 0, 0, "R6");
    // each select missing in turn
    issue(2, 9, '0, pat(9, 9), 1, 0, "R5");
    issue(2, 10, '0, pat(10, 9), 2, 0, "R5");
    issue(2, 11, '0, pat(11, 9), 3, 0, "R5");
    issue(1, 12, '1, '0, 2, 0, "R5");
    issue(1, 9, '1, '0, 0, 0, "R5");
    issue(1, 10, '1, '0, 0, 0, "R5");
    issue(1, 11, '1, '0, 0, 0, "R5");
    // stall in a read slot, then in a write slot
    issue(1, 13, '1, '0, 0, 0, "R7");
    issue(0, 0, '1, '0, 0, 0, "R7");
    stall();
    stall();
    issue(2, 14, '0, pat(14, 5), 0, 0, "R7");
    issue(0, 0, '1, '0, 0, 0, "R7");
    stall();
    issue(1, 14, '1, '0, 0, 0, "R7");
    issue(1, 15, '1, '0, 0, 1, "R8");
    repeat (4) issue(0, 0, '1, '0, 0, 0, "R4");

    // flow-through latency (R3, R4)
    flowN = 1'b0;
    for (int a = 0; a < 4; a++) issue(1, a, '1, '0, 0, 0, "R3");
    for (int i = 0; i < 6; i++) begin
      issue(2, 30 + i, '0, pat(30 + i, 6), 0, 0, "R4");
      issue(1, 30 + i, '1, '0, 0, 0, "R10");
    end
    issue(2, 40, 4'b1100, pat(40, 7), 0, 0, "R6");
    issue(2, 40, 4'b1001, pat(40, 8), 0, 0, "R9");
    issue(1, 40, '1, '0, 0, 0, "R9");
    issue(1, 41, '1, '0, 0, 0, "R7");
    stall();
    issue(1, 42, '1, '0, 0, 1, "R8");
    issue(1, 14, '1, '0, 0, 0, "R3");
    repeat (4) issue(0, 0, '1, '0, 0, 0, "R3");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule